// File: doc/BRIEF.md
# Pin Controller with Bit Set/Clear Aliases

This block is a memory-mapped general-purpose I/O controller for a parameterised number of pins (180 by default). Software reaches it over a plain 32-bit register bus: an address, a write strobe, write data and read data that is registered and valid one cycle after the address is presented. The bus never stalls. Every cycle is accepted, so there is no valid/ready pair and no back-pressure. Each pin has a direction bit, an output-data bit, a synchronised input bit and a 4-bit function selector.

The direction and output-data words each have three views at fixed offsets inside a 16-byte slot: the plain value, a write-one-to-set alias and a write-one-to-clear alias. Through the aliases a driver can flip single pins with one write and no read-modify-write. The function selector decides, per pin, whether the pad is driven from the controller's own registers or from an alternate-function source that enters on a per-pin input bus.

Top module: `gpio_alias_ctrl`

## Requirements
- R1: After reset every direction bit is 0 (input), every output-data bit is 0 and every function field is 0, so pad_oe is 0 on all pins.
- R2: Byte offsets select regions: direction at 0x000, output data at 0x100, input data at 0x200, function select from 0x300 up. Pin n sits in word n/32 at bit n%32, and that word's slot starts at region base + 0x10*(n/32).
- R3: Writing slot offset +0x0 of a direction or output-data word loads the whole word. Reading +0x0 returns it.
- R4: A write to slot offset +0x4 of a direction or output-data word sets every bit written as 1 and leaves the other bits unchanged.
- R5: A write to slot offset +0x8 of a direction or output-data word clears every bit written as 1 and leaves the other bits unchanged.
- R6: The +0x4 and +0x8 aliases read as zero. The input-data and function regions decode only offset +0x0, and writes to their +0x4 and +0x8 offsets change nothing.
- R7: The input-data region is read-only. It returns pad_in after a two-flop synchroniser, so a pad change is first visible in bus_rdata three rising edges after it is applied.
- R8: Function select holds 4 bits per pin, eight pins per word. Pin n is at word n/8, bits (n%8)*4 to (n%8)*4+3, and that word's slot is at 0x300 + 0x10*(n/8).
- R9: When a pin's function field is 0, pad_oe equals its direction bit and pad_out equals its output-data bit. For any other value, pad_oe and pad_out follow alt_oe and alt_out for that pin.
- R10: Reads of unmapped offsets return 0, and writes to them are ignored. Unmapped offsets are slots beyond the last word, offsets other than +0x0/+0x4/+0x8, and misaligned addresses. Bits of the last partial word that have no pin read as 0 and cannot be set.
- R11: bus_rdata is registered and reflects the address presented in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the previous cycle's address |
| pad_in | input | PIN_COUNT | Asynchronous pad levels |
| alt_oe | input | PIN_COUNT | Alternate-function output enable per pin |
| alt_out | input | PIN_COUNT | Alternate-function output value per pin |
| pad_oe | output | PIN_COUNT | Pad output enable (1 = drive) |
| pad_out | output | PIN_COUNT | Pad output value |

## Verification
The assertions assume that bus_addr, bus_we and bus_wdata are stable across each rising edge and carry no unknown values once reset is released. The alias checks look at fixed addresses in slot 0 of the direction and output-data regions. The mux checks assume alt_oe and alt_out are driven. pad_in may change at any moment, because no property compares it directly, only its synchronised copy through the bus. The stimulus changes every input on the falling clock edge, keeps the alternate buses at constant levels while the register table runs, and toggles a single pad only in the synchroniser test.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;
  localparam int WORD_W        = 32;
  localparam int FSEL_W        = 4;
  localparam int FSEL_PER_WORD = WORD_W / FSEL_W;
  localparam int DIR_BASE      = 'h000;
  localparam int DOUT_BASE     = 'h100;
  localparam int DIN_BASE      = 'h200;
  localparam int FSEL_BASE     = 'h300;
  localparam int SLOT_SHIFT    = 4;

  typedef enum logic [2:0] {
    REG_NONE, REG_DIR, REG_DOUT, REG_DIN, REG_FSEL
  } reg_region_e;

  typedef enum logic [1:0] {
    ACC_VAL, ACC_SET, ACC_CLR, ACC_BAD
  } reg_access_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_alias_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_WORDS = 6,
  parameter int FSEL_WORDS = 23,
  localparam int SLOT_W    = ADDR_W - SLOT_SHIFT
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_region_e       region,
  output reg_access_e       access,
  output logic [SLOT_W-1:0] slot,
  output logic              hit
);
  logic [ADDR_W-1:0] fsel_off;

  always_comb begin
    fsel_off = addr - ADDR_W'(FSEL_BASE);
    unique case (addr[3:0])
      4'h0:    access = ACC_VAL;
      4'h4:    access = ACC_SET;
      4'h8:    access = ACC_CLR;
      default: access = ACC_BAD;
    endcase
    region = REG_NONE;
    slot   = '0;
    hit    = 1'b0;
    if (addr >= ADDR_W'(FSEL_BASE)) begin
      region = REG_FSEL;
      slot   = fsel_off[ADDR_W-1:SLOT_SHIFT];
      hit    = (access == ACC_VAL) && (int'(slot) < FSEL_WORDS);
    end else begin
      slot = SLOT_W'(addr[7:4]);
      unique case (addr[9:8])
        2'd0: region = REG_DIR;
        2'd1: region = REG_DOUT;
        2'd2: region = REG_DIN;
        default: region = REG_NONE;
      endcase
      if (int'(slot) < DATA_WORDS) begin
        if (region == REG_DIN) hit = (access == ACC_VAL);
        else if (region != REG_NONE) hit = (access != ACC_BAD);
      end
    end
  end
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_alias_pkg::*;
#(
  parameter int   PIN_COUNT = 180,
  parameter int   SLOT_W    = 8,
  parameter logic RESET_BIT = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_access_e          access,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [WORD_W-1:0]    wdata,
  output logic [PIN_COUNT-1:0] bits
);
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    localparam int WI = i / WORD_W;
    localparam int BI = i % WORD_W;
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RESET_BIT;
      end else if (wr_en && slot == SLOT_W'(WI)) begin
        case (access)
          ACC_VAL: q <= wdata[BI];
          ACC_SET: if (wdata[BI]) q <= 1'b1;
          ACC_CLR: if (wdata[BI]) q <= 1'b0;
          default: q <= q;
        endcase
      end
    end
    assign bits[i] = q;
  end
endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
  import gpio_alias_pkg::*;
#(
  parameter int PIN_COUNT = 180,
  parameter int SLOT_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SLOT_W-1:0]           slot,
  input  logic [WORD_W-1:0]           wdata,
  output logic [PIN_COUNT*FSEL_W-1:0] fsel
);
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_field
    localparam int WI = i / FSEL_PER_WORD;
    localparam int LO = (i % FSEL_PER_WORD) * FSEL_W;
    logic [FSEL_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en && slot == SLOT_W'(WI)) q <= wdata[LO +: FSEL_W];
    end
    assign fsel[i*FSEL_W +: FSEL_W] = q;
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 180,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_alias_pkg::*;
#(
  parameter int PIN_COUNT = 180
) (
  input  logic [PIN_COUNT*FSEL_W-1:0] fsel,
  input  logic [PIN_COUNT-1:0]        dir,
  input  logic [PIN_COUNT-1:0]        dout,
  input  logic [PIN_COUNT-1:0]        alt_oe,
  input  logic [PIN_COUNT-1:0]        alt_out,
  output logic [PIN_COUNT-1:0]        pad_oe,
  output logic [PIN_COUNT-1:0]        pad_out
);
  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_mux
    logic own;
    assign own        = (fsel[i*FSEL_W +: FSEL_W] == '0);
    assign pad_oe[i]  = own ? dir[i]  : alt_oe[i];
    assign pad_out[i] = own ? dout[i] : alt_out[i];
  end
endmodule

// File: rtl/gpio_alias_ctrl.sv
module gpio_alias_ctrl
  import gpio_alias_pkg::*;
#(
  parameter int PIN_COUNT = 180,
  parameter int ADDR_W    = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  input  logic [PIN_COUNT-1:0] pad_in,
  input  logic [PIN_COUNT-1:0] alt_oe,
  input  logic [PIN_COUNT-1:0] alt_out,
  output logic [PIN_COUNT-1:0] pad_oe,
  output logic [PIN_COUNT-1:0] pad_out
);
  localparam int SLOT_W     = ADDR_W - SLOT_SHIFT;
  localparam int DATA_WORDS = (PIN_COUNT + WORD_W - 1) / WORD_W;
  localparam int FSEL_WORDS = (PIN_COUNT + FSEL_PER_WORD - 1) / FSEL_PER_WORD;
  localparam int DATA_PAD   = DATA_WORDS * WORD_W;
  localparam int FSEL_PAD   = FSEL_WORDS * WORD_W;

  reg_region_e              dec_region;
  reg_access_e              dec_access;
  logic [SLOT_W-1:0]        dec_slot;
  logic                     dec_hit;
  logic                     wr_hit;
  logic [PIN_COUNT-1:0]     dir_q, dout_q, din_q;
  logic [PIN_COUNT*FSEL_W-1:0] fsel_q;
  logic [DATA_PAD-1:0]      dir_pad, dout_pad, din_pad;
  logic [FSEL_PAD-1:0]      fsel_pad;
  logic [WORD_W-1:0]        rd_next;

  gpio_addr_dec #(.ADDR_W(ADDR_W), .DATA_WORDS(DATA_WORDS), .FSEL_WORDS(FSEL_WORDS)) u_dec (
    .addr(bus_addr), .region(dec_region), .access(dec_access), .slot(dec_slot), .hit(dec_hit)
  );

  assign wr_hit = bus_we && dec_hit;

  gpio_setclr_bank #(.PIN_COUNT(PIN_COUNT), .SLOT_W(SLOT_W), .RESET_BIT(1'b0)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_hit && dec_region == REG_DIR),
    .access(dec_access), .slot(dec_slot), .wdata(bus_wdata), .bits(dir_q)
  );

  gpio_setclr_bank #(.PIN_COUNT(PIN_COUNT), .SLOT_W(SLOT_W), .RESET_BIT(1'b0)) u_dout (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_hit && dec_region == REG_DOUT),
    .access(dec_access), .slot(dec_slot), .wdata(bus_wdata), .bits(dout_q)
  );

  gpio_fsel_bank #(.PIN_COUNT(PIN_COUNT), .SLOT_W(SLOT_W)) u_fsel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_hit && dec_region == REG_FSEL),
    .slot(dec_slot), .wdata(bus_wdata), .fsel(fsel_q)
  );

  gpio_in_sync #(.WIDTH(PIN_COUNT), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(din_q)
  );

  gpio_pad_mux #(.PIN_COUNT(PIN_COUNT)) u_mux (
    .fsel(fsel_q), .dir(dir_q), .dout(dout_q), .alt_oe(alt_oe), .alt_out(alt_out),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  // Zero-extend to whole words so spare bits of the last word read as 0.
  assign dir_pad  = DATA_PAD'(dir_q);
  assign dout_pad = DATA_PAD'(dout_q);
  assign din_pad  = DATA_PAD'(din_q);
  assign fsel_pad = FSEL_PAD'(fsel_q);

  always_comb begin
    rd_next = '0;
    if (dec_hit && dec_access == ACC_VAL) begin
      case (dec_region)
        REG_DIR:  rd_next = dir_pad[int'(dec_slot)*WORD_W +: WORD_W];
        REG_DOUT: rd_next = dout_pad[int'(dec_slot)*WORD_W +: WORD_W];
        REG_DIN:  rd_next = din_pad[int'(dec_slot)*WORD_W +: WORD_W];
        REG_FSEL: rd_next = fsel_pad[int'(dec_slot)*WORD_W +: WORD_W];
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_alias_ctrl_chk.sv
module gpio_alias_ctrl_chk
  import gpio_alias_pkg::*;
#(
  parameter int PIN_COUNT = 180,
  parameter int ADDR_W    = 12
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_we,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic [WORD_W-1:0]           bus_wdata,
  input logic [WORD_W-1:0]           bus_rdata,
  input logic                        dec_hit,
  input logic [PIN_COUNT-1:0]        dir_q,
  input logic [PIN_COUNT-1:0]        dout_q,
  input logic [PIN_COUNT*FSEL_W-1:0] fsel_q,
  input logic [PIN_COUNT-1:0]        alt_oe,
  input logic [PIN_COUNT-1:0]        alt_out,
  input logic [PIN_COUNT-1:0]        pad_oe,
  input logic [PIN_COUNT-1:0]        pad_out
);
  localparam int LAST = PIN_COUNT - 1;

  // R4
  dir_set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(DIR_BASE + 4) && bus_wdata[0]) |=> dir_q[0]);

  // R5
  dout_clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(DOUT_BASE + 8) && bus_wdata[0]) |=> !dout_q[0]);

  // R10
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !dec_hit) |=> ($stable(dir_q) && $stable(dout_q) && $stable(fsel_q)));

  // R10
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |=> (bus_rdata == '0));

  // R9
  own_pin_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel_q[FSEL_W-1:0] == '0) |-> (pad_oe[0] == dir_q[0] && pad_out[0] == dout_q[0]));

  // R9
  alt_pin_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel_q[LAST*FSEL_W +: FSEL_W] != '0) |-> (pad_oe[LAST] == alt_oe[LAST] && pad_out[LAST] == alt_out[LAST]));
endmodule

bind gpio_alias_ctrl gpio_alias_ctrl_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .dec_hit(dec_hit), .dir_q(dir_q), .dout_q(dout_q), .fsel_q(fsel_q),
  .alt_oe(alt_oe), .alt_out(alt_out), .pad_oe(pad_oe), .pad_out(pad_out)
);

// File: tb/gpio_alias_ctrl_test.sv
`timescale 1ns/1ps
module gpio_alias_ctrl_test;
  localparam int N  = 180;
  localparam int AW = 12;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 12'h000, 32'h0000_0000, 4'd1},   // R1 direction reset
    '{1'b0, 12'h300, 32'h0000_0000, 4'd1},   // R1 function reset
    '{1'b1, 12'h000, 32'hA5A5_0F0F, 4'd3},   // R3 value write
    '{1'b0, 12'h000, 32'hA5A5_0F0F, 4'd3},
    '{1'b1, 12'h004, 32'h0000_00F0, 4'd4},   // R4 set alias
    '{1'b0, 12'h000, 32'hA5A5_0FFF, 4'd4},
    '{1'b1, 12'h008, 32'hA000_000F, 4'd5},   // R5 clear alias
    '{1'b0, 12'h000, 32'h05A5_0FF0, 4'd5},
    '{1'b0, 12'h004, 32'h0000_0000, 4'd6},   // R6 alias reads zero
    '{1'b1, 12'h110, 32'h1234_5678, 4'd2},   // R2 output word 1
    '{1'b0, 12'h110, 32'h1234_5678, 4'd2},
    '{1'b0, 12'h100, 32'h0000_0000, 4'd2},
    '{1'b1, 12'h050, 32'hFFFF_FFFF, 4'd10},  // R10 partial last word
    '{1'b0, 12'h050, 32'h000F_FFFF, 4'd10},
    '{1'b1, 12'h058, 32'hFFF0_0001, 4'd5},
    '{1'b0, 12'h050, 32'h000F_FFFE, 4'd5},
    '{1'b1, 12'h060, 32'hFFFF_FFFF, 4'd10},  // R10 slot past end
    '{1'b0, 12'h060, 32'h0000_0000, 4'd10},
    '{1'b1, 12'h200, 32'hFFFF_FFFF, 4'd7},   // R7 input bank read-only
    '{1'b0, 12'h200, 32'h0000_0000, 4'd7},
    '{1'b1, 12'h310, 32'h7654_3210, 4'd8},   // R8 function word 1
    '{1'b0, 12'h310, 32'h7654_3210, 4'd8},
    '{1'b1, 12'h314, 32'hFFFF_FFFF, 4'd6},   // R6 no alias on function
    '{1'b0, 12'h310, 32'h7654_3210, 4'd6},
    '{1'b1, 12'h460, 32'hFFFF_FFFF, 4'd10},  // R10 last function word
    '{1'b0, 12'h460, 32'h0000_FFFF, 4'd10},
    '{1'b0, 12'h470, 32'h0000_0000, 4'd10},
    '{1'b0, 12'h002, 32'h0000_0000, 4'd10},  // misaligned
    '{1'b0, 12'h0F0, 32'h0000_0000, 4'd10},
    '{1'b0, 12'h114, 32'h0000_0000, 4'd11}   // R11 read of set alias of written word
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  alt_oe = '0;
  logic [N-1:0]  alt_out = '0;
  logic [N-1:0]  pad_oe, pad_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_alias_ctrl #(.PIN_COUNT(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .alt_oe(alt_oe), .alt_out(alt_out),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_we = 1'b0; bus_addr = a;
    @(negedge clk); check(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: pads released after reset
    check("R1 pad_oe", 32'(pad_oe[31:0]), 32'h0);
    check("R1 pad_out", 32'(pad_out[31:0]), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else rd(VECS[i].addr, VECS[i].data, $sformatf("R%0d addr %h", VECS[i].req, VECS[i].addr));
    end

    // R9: pins 9..15 use alternate sources, pins 0..8 and 32..63 use own registers
    alt_oe = '1; alt_out = '1;
    @(negedge clk);
    check("R9 pad_oe low word", pad_oe[31:0], 32'h05A5_0FF0 | 32'h0000_FE00);
    check("R9 pad_out low word", pad_out[31:0], 32'h0000_FE00);
    check("R9 pad_out word1", pad_out[63:32], 32'h1234_5678);
    alt_oe = '0;
    @(negedge clk);
    check("R9 alt pin 179", 32'(pad_oe[179]), 32'h0);
    wr(12'h310, 32'h0);
    @(negedge clk);
    check("R9 back to own", 32'(pad_oe[15:8]), 32'h0F);

    // R7: two-flop synchroniser plus registered read
    @(negedge clk); bus_we = 1'b0; bus_addr = 12'h200; pad_in[3] = 1'b1;
    @(negedge clk); check("R7 sync 1 edge", bus_rdata, 32'h0);
    @(negedge clk); check("R7 sync 2 edges", bus_rdata, 32'h0);
    @(negedge clk); check("R7 sync 3 edges", bus_rdata, 32'h8);

    // R1: reset mid-run restores defaults
    alt_oe = '1;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(12'h000, 32'h0, "R1 dir after reset");
    rd(12'h110, 32'h0, "R1 dout after reset");
    rd(12'h460, 32'h0, "R1 fsel after reset");
    check("R1 pad_oe after reset", pad_oe[31:0], 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule